// File: doc/BRIEF.md
# Burst-Reordering Line Read Buffer

This block holds one cache line of quadwords (64-bit entries) that a PCI-side master has asked to read, and hands it out as 32-bit words on a bus-style data output. A line is opened with a start pulse that carries the index of the requested quadword. The line then fills from one of two write ports. The memory-side port delivers quadwords in linear order, beginning at the requested one. The cache-side port delivers a writeback in interleaved burst order. In that order, beat `b` carries quadword `req XOR b`. The buffer computes the storage slot for each beat directly from the beat number, so that the requested quadword always sits in slot 0 and the rest follow in ascending order. Quadwords below the requested one are dropped.

The drain side walks the slots upward and sends the low 32 bits of each slot before its high 32 bits. It waits on any slot that has not been filled yet, and it stops once every quadword from the requested one to the end of the line has been sent. Each output word carries one parity bit. That bit is folded from the byte parity supplied with the data. When the cache source reports that it has no parity, the block generates byte parity from the data when it stores the entry.

Top module: `pci_line_rdbuf`

## Requirements
- R1: After reset, `pci_vld`, `pci_done` and `pci_ad` are 0, and no word is sent before a line has been filled, even with `drain_en` held high.
- R2: A `line_start` cycle captures `line_req_qw`, marks every slot empty and restarts the drain at slot 0. A write on either port in that same cycle is ignored.
- R3: Cache beat `b` (counted from 0 after `line_start`) carries quadword `q = line_req_qw XOR b`. If `q >= line_req_qw`, the beat is stored in slot `q - line_req_qw`. Otherwise it is discarded.
- R4: Memory beat `k` is stored in slot `k` while `k < NQW - line_req_qw`. Later memory beats, and cache beats after the first `NQW`, are ignored.
- R5: The drain sends slots in ascending order, low dword (bits 31:0) first and then high dword (bits 63:32). A word appears on `pci_ad` with `pci_vld`=1 on the cycle after a cycle in which `drain_en` was 1, the slot was filled, and the line was not finished.
- R6: If `drain_en` is 0 or the current slot is empty, `pci_vld` is 0 on the next cycle and the drain position holds.
- R7: For memory writes, and for cache writes with `cache_par_ok`=1, `pci_par` is the XOR of the supplied byte-parity bits 3:0 for a low dword, or bits 7:4 for a high dword.
- R8: For cache writes with `cache_par_ok`=0, the supplied parity is ignored and `pci_par` is the XOR of the 32 data bits driven on `pci_ad`.
- R9: `pci_done` rises once `2*(NQW - line_req_qw)` words have been sent. After that, no word is sent until the next `line_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Opens a new line |
| line_req_qw | input | $clog2(NQW) | Requested quadword, sampled with `line_start` |
| mem_wr_en | input | 1 | Memory-side beat valid |
| mem_wr_data | input | 64 | Memory-side quadword |
| mem_wr_bpar | input | 8 | Memory-side byte parity, bit i for byte i |
| cache_wr_en | input | 1 | Cache-side beat valid |
| cache_wr_data | input | 64 | Cache-side quadword |
| cache_wr_bpar | input | 8 | Cache-side byte parity, bit i for byte i |
| cache_par_ok | input | 1 | Cache beat carries usable parity |
| drain_en | input | 1 | Permits one word to be sent this cycle |
| pci_ad | output | 32 | Registered output word |
| pci_par | output | 1 | Parity of the output word |
| pci_vld | output | 1 | `pci_ad` holds a new word |
| pci_done | output | 1 | All words of the line have been sent |

## Verification
The hardest case to reach from the ports is the drain catching up with the fill while the fill is still in progress. The sequencer then has to stall on an empty slot and resume at exactly the right half-word once that slot lands. The bench reaches this case by holding `drain_en` high from the start of the line while it spaces the write beats several cycles apart. It repeats this for every requested quadword and every source, and it also runs a pass in which `drain_en` toggles every cycle. A start cycle that carries a write, followed by an idle drain window, shows that the write was ignored.

// File: rtl/pci_rdbuf_pkg.sv
package pci_rdbuf_pkg;

  typedef struct packed {
    logic [7:0]  bpar;
    logic [63:0] data;
  } qw_entry_t;

  // Even parity per byte, bit i covering byte i.
  function automatic logic [7:0] gen_byte_par(input logic [63:0] d);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ^d[8*i +: 8];
    return p;
  endfunction

endpackage

// File: rtl/rdbuf_wr_map.sv
module rdbuf_wr_map #(
  parameter int NQW = 4,
  localparam int IW = $clog2(NQW),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic [IW-1:0] req,
  input  logic          mem_we,
  input  logic          cache_we,
  output logic          wr_en,
  output logic          wr_from_cache,
  output logic [IW-1:0] wr_slot
);

  logic [CW-1:0] mem_beat, cache_beat;
  logic [CW-1:0] line_len;
  logic [IW-1:0] cache_qw, cache_slot;
  logic          mem_keep, cache_keep;

  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      mem_beat   <= '0;
      cache_beat <= '0;
    end else begin
      if (mem_we && mem_beat != CW'(NQW))     mem_beat   <= mem_beat + 1'b1;
      if (cache_we && cache_beat != CW'(NQW)) cache_beat <= cache_beat + 1'b1;
    end
  end

  always_comb begin
    line_len   = CW'(NQW) - {1'b0, req};
    cache_qw   = req ^ cache_beat[IW-1:0];
    cache_slot = cache_qw - req;
    cache_keep = cache_we && !line_start && (cache_beat < CW'(NQW)) && (cache_qw >= req);
    mem_keep   = mem_we && !line_start && (mem_beat < line_len);
    wr_en         = cache_keep || mem_keep;
    wr_from_cache = cache_keep;
    wr_slot       = cache_keep ? cache_slot : mem_beat[IW-1:0];
  end

endmodule

// File: rtl/rdbuf_store.sv
module rdbuf_store
  import pci_rdbuf_pkg::*;
#(
  parameter int NQW = 4,
  localparam int IW = $clog2(NQW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] wslot,
  input  qw_entry_t     wentry,
  input  logic          re,
  input  logic [IW-1:0] raddr,
  input  logic          rhalf,
  output logic [NQW-1:0] valid,
  output logic [31:0]   rd_dw,
  output logic          rd_par
);

  qw_entry_t mem [NQW];
  qw_entry_t rd_ent;

  // Storage array without reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[wslot] <= wentry;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  valid <= '0;
    else if (we)     valid[wslot] <= 1'b1;
  end

  assign rd_ent = mem[raddr];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_dw  <= '0;
      rd_par <= 1'b0;
    end else if (re) begin
      rd_dw  <= rhalf ? rd_ent.data[63:32] : rd_ent.data[31:0];
      rd_par <= rhalf ? ^rd_ent.bpar[7:4] : ^rd_ent.bpar[3:0];
    end
  end

endmodule

// File: rtl/rdbuf_drain.sv
module rdbuf_drain #(
  parameter int NQW = 4,
  localparam int IW = $clog2(NQW),
  localparam int PW = IW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           line_start,
  input  logic [IW-1:0]  req,
  input  logic           drain_en,
  input  logic [NQW-1:0] valid,
  output logic           fire,
  output logic [IW-1:0]  rd_slot,
  output logic           rd_half,
  output logic           done,
  output logic           vld_q
);

  logic [PW-1:0] ptr;
  logic [PW-1:0] total;

  always_comb begin
    total   = {(PW-1)'(NQW) - {{(PW-1-IW){1'b0}}, req}, 1'b0};
    rd_slot = ptr[IW:1];
    rd_half = ptr[0];
    done    = (ptr == total);
    fire    = drain_en && !line_start && !done && valid[rd_slot];
  end

  always_ff @(posedge clk) begin
    if (rst || line_start) ptr <= '0;
    else if (fire)         ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= fire;
  end

endmodule

// File: rtl/pci_line_rdbuf.sv
module pci_line_rdbuf
  import pci_rdbuf_pkg::*;
#(
  parameter int NQW = 4,
  localparam int IW = $clog2(NQW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic [IW-1:0] line_req_qw,
  input  logic          mem_wr_en,
  input  logic [63:0]   mem_wr_data,
  input  logic [7:0]    mem_wr_bpar,
  input  logic          cache_wr_en,
  input  logic [63:0]   cache_wr_data,
  input  logic [7:0]    cache_wr_bpar,
  input  logic          cache_par_ok,
  input  logic          drain_en,
  output logic [31:0]   pci_ad,
  output logic          pci_par,
  output logic          pci_vld,
  output logic          pci_done
);

  logic [IW-1:0]  req_q;
  logic           wr_en, wr_from_cache;
  logic [IW-1:0]  wr_slot;
  qw_entry_t      wentry;
  logic [NQW-1:0] valid;
  logic           fire, rd_half;
  logic [IW-1:0]  rd_slot;

  always_ff @(posedge clk) begin
    if (rst)             req_q <= '0;
    else if (line_start) req_q <= line_req_qw;
  end

  always_comb begin
    if (wr_from_cache) begin
      wentry.data = cache_wr_data;
      wentry.bpar = cache_par_ok ? cache_wr_bpar : gen_byte_par(cache_wr_data);
    end else begin
      wentry.data = mem_wr_data;
      wentry.bpar = mem_wr_bpar;
    end
  end

  rdbuf_wr_map #(.NQW(NQW)) u_map (
    .clk(clk), .rst(rst), .line_start(line_start), .req(req_q),
    .mem_we(mem_wr_en), .cache_we(cache_wr_en),
    .wr_en(wr_en), .wr_from_cache(wr_from_cache), .wr_slot(wr_slot)
  );

  rdbuf_store #(.NQW(NQW)) u_store (
    .clk(clk), .rst(rst), .clr(line_start),
    .we(wr_en), .wslot(wr_slot), .wentry(wentry),
    .re(fire), .raddr(rd_slot), .rhalf(rd_half),
    .valid(valid), .rd_dw(pci_ad), .rd_par(pci_par)
  );

  rdbuf_drain #(.NQW(NQW)) u_drain (
    .clk(clk), .rst(rst), .line_start(line_start), .req(req_q),
    .drain_en(drain_en), .valid(valid),
    .fire(fire), .rd_slot(rd_slot), .rd_half(rd_half),
    .done(pci_done), .vld_q(pci_vld)
  );

endmodule

// File: rtl/pci_line_rdbuf_chk.sv
module pci_line_rdbuf_chk (
  input logic clk,
  input logic rst,
  input logic line_start,
  input logic drain_en,
  input logic pci_vld,
  input logic pci_done
);

  // R2: a new line sends nothing on the next cycle and is not finished
  a_r2_start_quiet: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (!pci_vld && !pci_done));

  // R6: no permission, no word
  a_r6_no_drain_no_word: assert property (@(posedge clk) disable iff (rst)
    !drain_en |=> !pci_vld);

  // R9: a finished line sends nothing more until restarted
  a_r9_done_silent: assert property (@(posedge clk) disable iff (rst)
    (pci_done && !line_start) |=> !pci_vld);

  // R9: done stays high until a new line starts
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (pci_done && !line_start) |=> pci_done);

  // R1: output flags are always known
  a_r1_flags_known: assert property (@(posedge clk) disable iff (rst)
    !$isunknown({pci_vld, pci_done}));

endmodule

bind pci_line_rdbuf pci_line_rdbuf_chk u_chk (
  .clk(clk), .rst(rst), .line_start(line_start), .drain_en(drain_en),
  .pci_vld(pci_vld), .pci_done(pci_done)
);

// File: tb/test_pci_line_rdbuf.sv
module test_pci_line_rdbuf;
  localparam int NQ = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_start = 1'b0;
  logic [1:0]  line_req_qw = '0;
  logic        mem_wr_en = 1'b0;
  logic [63:0] mem_wr_data = '0;
  logic [7:0]  mem_wr_bpar = '0;
  logic        cache_wr_en = 1'b0;
  logic [63:0] cache_wr_data = '0;
  logic [7:0]  cache_wr_bpar = '0;
  logic        cache_par_ok = 1'b0;
  logic        drain_en = 1'b0;
  logic [31:0] pci_ad;
  logic        pci_par, pci_vld, pci_done;

  int checks = 0, errors = 0;
  int line_id = 0, cur_src = 0, exp_n = 0, got_n = 0;
  logic [31:0] exp_ad [8];
  logic        exp_par [8];
  logic        drain_prev = 1'b0;

  always #4 clk = ~clk;

  pci_line_rdbuf #(.NQW(NQ)) i_pci_line_rdbuf (.*);

  function automatic logic [63:0] qd(input int ln, input int q);
    logic [31:0] a = 32'(ln * 8 + q + 1) * 32'h9E37_79B9;
    return {a, a ^ 32'h5A5A_0F0F ^ 32'(q << 28)};
  endfunction

  function automatic logic [7:0] qp(input int ln, input int q);
    return 8'(ln * 37 + q * 11 + 3);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) drain_prev <= drain_en;

  always @(negedge clk) begin
    if (!rst && pci_vld) begin
      // R6: a word only follows a cycle with drain_en high
      chk(drain_prev, "R6", "word without drain_en", 1, 0);
      if (got_n >= exp_n) begin
        chk(1'b0, "R9", "extra word after line end", 64'(got_n), 64'(exp_n));
      end else begin
        chk(pci_ad == exp_ad[got_n], cur_src == 0 ? "R4" : "R3",
            "data word (R5 order)", 64'(pci_ad), 64'(exp_ad[got_n]));
        chk(pci_par == exp_par[got_n], cur_src == 2 ? "R8" : "R7",
            "parity", 64'(pci_par), 64'(exp_par[got_n]));
      end
      got_n++;
    end
  end

  task automatic run_line(input int req, input int src, input int mode);
    logic [63:0] d;
    logic [7:0]  p;
    line_id++;
    cur_src = src;
    exp_n = 2 * (NQ - req);
    got_n = 0;
    for (int s = 0; s < NQ - req; s++) begin
      d = qd(line_id, req + s);
      p = qp(line_id, req + s);
      exp_ad[2*s]     = d[31:0];
      exp_ad[2*s + 1] = d[63:32];
      exp_par[2*s]     = (src == 2) ? ^d[31:0]  : ^p[3:0];
      exp_par[2*s + 1] = (src == 2) ? ^d[63:32] : ^p[7:4];
    end
    // R2: write in the start cycle must be ignored
    @(negedge clk);
    line_start = 1'b1; line_req_qw = 2'(req);
    mem_wr_en = 1'b1; mem_wr_data = '1; mem_wr_bpar = 8'hFF;
    @(negedge clk);
    line_start = 1'b0; mem_wr_en = 1'b0; drain_en = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(got_n == 0, "R2", "word sent from start-cycle write", 64'(got_n), 0);
    chk(pci_done == 1'b0, "R2", "done right after start", 64'(pci_done), 0);
    drain_en = (mode == 1);
    for (int b = 0; b <= NQ; b++) begin
      int  q;
      bit  inr;
      q   = (src == 0) ? req + b : (req ^ b);
      inr = (src == 0) ? (req + b < NQ) : (b < NQ);
      d = inr ? qd(line_id, q) : 64'hDEAD_BEEF_0BAD_F00D;
      p = inr ? qp(line_id, q) : 8'hA5;
      @(negedge clk);
      if (src == 0) begin
        mem_wr_en = 1'b1; mem_wr_data = d; mem_wr_bpar = p;
      end else begin
        cache_wr_en = 1'b1; cache_wr_data = d;
        cache_par_ok = (src == 1);
        cache_wr_bpar = (src == 1) ? p : ~pci_rdbuf_pkg::gen_byte_par(d);
      end
      @(negedge clk);
      mem_wr_en = 1'b0; cache_wr_en = 1'b0;
      if (mode == 1) repeat (2) @(negedge clk);
    end
    if (mode == 2) begin
      for (int c = 0; c < 40; c++) begin
        drain_en = c[0];
        @(negedge clk);
      end
    end else begin
      drain_en = 1'b1;
      repeat (20) @(negedge clk);
    end
    drain_en = 1'b0;
    @(negedge clk);
    #1;
    chk(got_n == exp_n, "R5", "word count", 64'(got_n), 64'(exp_n));
    chk(pci_done == 1'b1, "R9", "done after line", 64'(pci_done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(pci_vld == 1'b0, "R1", "vld after reset", 64'(pci_vld), 0);
    chk(pci_done == 1'b0, "R1", "done after reset", 64'(pci_done), 0);
    chk(pci_ad == 32'h0, "R1", "ad after reset", 64'(pci_ad), 0);
    drain_en = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    chk(pci_vld == 1'b0 && got_n == 0, "R1", "word before any fill", 64'(got_n), 0);
    drain_en = 1'b0;
    for (int mode = 0; mode < 3; mode++)
      for (int src = 0; src < 3; src++)
        for (int req = 0; req < NQ; req++)
          run_line(req, src, mode);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule